// File: doc/BRIEF.md
# VCO Band Calibrator (Successive Approximation)

This block picks the switched-capacitor band code of a wideband oscillator whenever a new channel is programmed. While the charge-pump loop is held open and the tuning voltage is parked, it drives a trial band code. It waits a short settling interval, then counts rising edges of the divided oscillator over a fixed window of calibration-clock cycles. It compares that count with a programmed target and decides one code bit, starting at the most significant bit and ending at the least significant. A larger code means less bank capacitance and therefore a higher oscillator frequency. When the target count is above the measured count, the tested bit stays set. Otherwise it is cleared.

When the last bit has been decided, the code is frozen, a done flag rises and the loop-select output hands the oscillator to the closed phase-lock loop. The calibration clock may be the reference multiplied by one, two or four. A rate selector shrinks the window to match, so a faster clock shortens the search. The measured count is scaled back up before the comparison, so the same target applies at every rate. A new start pulse at any time abandons the current search and begins a fresh one.

Top module: `afc_band_cal`

## Requirements
- R1: After reset `band_code` is the mid code (only the MSB set, 128 for K=8), and `cal_done` and `pll_loop_en` are low.
- R2: The cycle after `cal_start` is sampled high, `band_code` is the mid code and both `cal_done` and `pll_loop_en` are low.
- R3: The code is resolved MSB first, one bit per window. Bits below the bit under test are zero while it is tested. The edge counter restarts from zero for every window.
- R4: A tested bit is kept when the scaled edge count is strictly below `target_count` and cleared otherwise. The final code is therefore the largest code whose count is below the target. It is all zeros when no code qualifies and all ones when every code does.
- R5: `pll_loop_en` and `cal_done` rise together in the cycle after the last bit decision and stay low during the whole search.
- R6: Every bit takes SETTLE_CYC settling cycles, then W counting cycles, then one decision cycle. Here W = WIN_BASE >> s, with s = 0, 1, 2 for `rate_sel` = 0, 1, 2 and s = 2 for `rate_sel` = 3. `cal_done` is visible K*(SETTLE_CYC+W+1) clock edges after the start edge.
- R7: Before the comparison the window count is shifted left by s. A search at the x2 or x4 rate lands within 2<<s codes of the result the x1 rate gives for the same target.
- R8: A `cal_start` during a search aborts it. The search then restarts from the mid code and takes the full duration of R6 from the new start edge.
- R9: Once `cal_done` is high, `band_code`, `cal_done` and `pll_loop_en` hold until the next `cal_start`. Oscillator edges and changes on `target_count` or `rate_sel` have no effect on them.
- R10: Edges arriving during the settling interval after a code change are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Calibration clock (reference times 1, 2 or 4) |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | One-cycle request to begin (or restart) a band search |
| target_count | input | TGT_W | Expected divided-oscillator edges per full-length window, latched at start |
| rate_sel | input | 2 | Calibration clock multiple: 0 = x1, 1 = x2, 2 or 3 = x4; latched at start |
| vco_div_in | input | 1 | Divided oscillator signal, asynchronous to `clk` |
| band_code | output | K | Capacitor-bank code, trial value during the search, final value after |
| pll_loop_en | output | 1 | High hands the oscillator to the closed phase-lock loop |
| cal_done | output | 1 | High once the band code is final |

## Verification
The bench models the oscillator as a phase accumulator whose step grows linearly with the band code. At the x1 rate it makes exactly code+4 edges per window, so the correct final code is known in closed form. Targets at the very bottom and top of the range check the all-cleared and all-kept outcomes. A design with the compare inverted, or with a non-strict compare, misses these by a code or more. A design that keeps the count from one window to the next gets a wrong code even in mid-range. The search length is counted edge by edge at each rate, so a window, settle or decision cycle too many or too few shows up at once. A start in the middle of a search checks that the code returns to mid-scale and that the full duration restarts. A design that resumes the old search would finish early. After completion the bench changes the target and rate and lets oscillator edges run, to catch a code that keeps moving.

// File: rtl/afc_cal_pkg.sv
package afc_cal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_COUNT  = 3'd2,
        ST_DECIDE = 3'd3,
        ST_DONE   = 3'd4
    } cal_state_e;

    typedef enum logic [1:0] {
        RATE_X1     = 2'd0,
        RATE_X2     = 2'd1,
        RATE_X4     = 2'd2,
        RATE_X4_ALT = 2'd3
    } win_rate_e;

    // Control bundle from the sequencer to the window counter
    typedef struct packed {
        logic tmr_clr;
        logic cnt_clr;
        logic tick_en;
        logic cnt_en;
    } win_ctl_t;

    // Left shift applied to the window count for a given clock multiple
    function automatic logic [1:0] rate_shift(input logic [1:0] sel);
        case (sel)
            RATE_X1: rate_shift = 2'd0;
            RATE_X2: rate_shift = 2'd1;
            default: rate_shift = 2'd2;
        endcase
    endfunction

    function automatic logic is_busy(input cal_state_e st);
        is_busy = (st == ST_SETTLE) || (st == ST_COUNT) || (st == ST_DECIDE);
    endfunction

endpackage

// File: rtl/afc_edge_sync.sv
module afc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

    // A rising edge needs a low sample between two reports (R10 counting basis)
    p_single_rise_r10: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/afc_win_ctr.sv
module afc_win_ctr
    import afc_cal_pkg::*;
#(
    parameter int TMR_W = 10,
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  win_ctl_t         ctl,
    input  logic             rise_i,
    input  logic [TMR_W-1:0] limit_i,
    output logic             last_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [TMR_W-1:0] tmr_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || ctl.tmr_clr) tmr_q <= '0;
        else if (ctl.tick_en)   tmr_q <= tmr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.cnt_clr)                        cnt_q <= '0;
        else if (ctl.cnt_en && rise_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign last_o  = (tmr_q == limit_i);
    assign count_o = cnt_q;

    // Timer never runs past the interval end it was given
    p_timer_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        ctl.tick_en |-> (tmr_q <= limit_i));

    // Each counted edge adds exactly one
    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctl.cnt_clr && ctl.cnt_en && rise_i && cnt_q != CNT_MAX)
        |=> (cnt_q == $past(cnt_q) + 1'b1));

    // Nothing is counted outside a counting window
    p_no_count_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!ctl.cnt_clr && !ctl.cnt_en) |=> $stable(cnt_q));

endmodule

// File: rtl/afc_sar.sv
module afc_sar #(
    parameter int K = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         step_i,
    input  logic         keep_i,
    output logic [K-1:0] code_o,
    output logic         last_o
);

    localparam int          IDX_W   = (K > 1) ? $clog2(K) : 1;
    localparam logic [K-1:0] MID    = {1'b1, {(K-1){1'b0}}};
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(K-1);

    logic [K-1:0]     code_q, code_n;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        code_n = code_q;
        if (!keep_i)
            code_n[idx_q] = 1'b0;
        if (idx_q != '0)
            code_n[idx_q - 1'b1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            code_q <= MID;
            idx_q  <= TOP_IDX;
        end else if (step_i) begin
            code_q <= code_n;
            if (idx_q != '0)
                idx_q <= idx_q - 1'b1;
        end
    end

    assign code_o = code_q;
    assign last_o = (idx_q == '0);

    // Bits not yet tested stay clear
    p_untested_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (code_q & ((K'(1) << idx_q) - K'(1))) == '0);

    // Bits above the tested one never change on a step
    p_upper_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && idx_q != TOP_IDX)
        |=> ((code_q >> ($past(idx_q) + 1'b1)) == ($past(code_q) >> ($past(idx_q) + 1'b1))));

endmodule

// File: rtl/afc_band_cal.sv
module afc_band_cal
    import afc_cal_pkg::*;
#(
    parameter int K           = 8,
    parameter int TGT_W       = 12,
    parameter int WIN_BASE    = 1024,
    parameter int SETTLE_CYC  = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cal_start,
    input  logic [TGT_W-1:0] target_count,
    input  logic [1:0]       rate_sel,
    input  logic             vco_div_in,
    output logic [K-1:0]     band_code,
    output logic             pll_loop_en,
    output logic             cal_done
);

    localparam int TMR_W = $clog2(WIN_BASE);
    localparam int CNT_W = $clog2(WIN_BASE + 1);
    localparam int SCL_W = CNT_W + 2;
    localparam int CMP_W = (SCL_W > TGT_W) ? SCL_W : TGT_W;
    localparam logic [K-1:0]     MID        = {1'b1, {(K-1){1'b0}}};
    localparam logic [TMR_W-1:0] SETTLE_LST = TMR_W'(SETTLE_CYC - 1);

    cal_state_e        state_q;
    logic [1:0]        shift_q;
    logic [TGT_W-1:0]  tgt_q;
    logic              done_q, loop_q;

    logic              rise;
    logic              last;
    logic [CNT_W-1:0]  count;
    logic [TMR_W-1:0]  limit;
    logic [TMR_W:0]    win_len;
    logic [SCL_W-1:0]  scaled;
    logic              keep;
    logic              sar_last;
    win_ctl_t          ctl;

    afc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (vco_div_in),
        .rise_o (rise)
    );

    // Interval length: settle phase or the rate-scaled window
    always_comb begin
        win_len = (TMR_W+1)'(WIN_BASE) >> shift_q;
        if (state_q == ST_SETTLE) limit = SETTLE_LST;
        else                      limit = TMR_W'(win_len - 1'b1);
    end

    always_comb begin
        ctl.tick_en = (state_q == ST_SETTLE) || (state_q == ST_COUNT);
        ctl.cnt_en  = (state_q == ST_COUNT);
        ctl.cnt_clr = cal_start || (state_q == ST_DECIDE);
        ctl.tmr_clr = cal_start || (state_q == ST_DECIDE) ||
                      (ctl.tick_en && last);
    end

    afc_win_ctr #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_win (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .rise_i  (rise),
        .limit_i (limit),
        .last_o  (last),
        .count_o (count)
    );

    always_comb begin
        scaled = SCL_W'(count) << shift_q;
        keep   = CMP_W'(scaled) < CMP_W'(tgt_q);
    end

    afc_sar #(.K(K)) u_sar (
        .clk    (clk),
        .rst    (rst),
        .load_i (cal_start),
        .step_i (state_q == ST_DECIDE && !cal_start),
        .keep_i (keep),
        .code_o (band_code),
        .last_o (sar_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            shift_q <= 2'd0;
            tgt_q   <= '0;
            done_q  <= 1'b0;
            loop_q  <= 1'b0;
        end else if (cal_start) begin
            state_q <= ST_SETTLE;
            shift_q <= rate_shift(rate_sel);
            tgt_q   <= target_count;
            done_q  <= 1'b0;
            loop_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_SETTLE: if (last) state_q <= ST_COUNT;
                ST_COUNT:  if (last) state_q <= ST_DECIDE;
                ST_DECIDE: begin
                    if (sar_last) begin
                        state_q <= ST_DONE;
                        done_q  <= 1'b1;
                        loop_q  <= 1'b1;
                    end else begin
                        state_q <= ST_SETTLE;
                    end
                end
                default: state_q <= state_q;
            endcase
        end
    end

    assign cal_done    = done_q;
    assign pll_loop_en = loop_q;

    p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
        cal_start |=> (!cal_done && !pll_loop_en && band_code == MID));

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (cal_start && is_busy(state_q)) |=> (state_q == ST_SETTLE));

    p_loop_low_busy_r5: assert property (@(posedge clk) disable iff (rst)
        is_busy(state_q) |-> (!pll_loop_en && !cal_done));

    p_done_after_decide_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_done) |-> ($past(state_q) == ST_DECIDE && pll_loop_en));

    p_hold_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        (cal_done && !cal_start) |=> ($stable(band_code) && cal_done && pll_loop_en));

endmodule

// File: tb/afc_band_cal_test.sv
module afc_band_cal_test;

    localparam int K        = 8;
    localparam int TGT_W    = 12;
    localparam int WIN_BASE = 1024;
    localparam int SETTLE   = 6;
    localparam int MID      = 128;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cal_start = 1'b0;
    logic [TGT_W-1:0] target_count = '0;
    logic [1:0]       rate_sel = 2'd0;
    logic             vco_div_in;
    logic [K-1:0]     band_code;
    logic             pll_loop_en;
    logic             cal_done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    // Oscillator model: x1 window of 1024 cycles sees exactly code+4 edges
    logic [15:0] acc;
    logic [15:0] inc;
    assign inc        = ({8'd0, band_code} << 6) + 16'd256;
    assign vco_div_in = acc[15];
    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= acc + inc;
    end

    afc_band_cal #(.K(K), .TGT_W(TGT_W), .WIN_BASE(WIN_BASE),
                   .SETTLE_CYC(SETTLE), .SYNC_STAGES(2)) uut (
        .clk          (clk),
        .rst          (rst),
        .cal_start    (cal_start),
        .target_count (target_count),
        .rate_sel     (rate_sel),
        .vco_div_in   (vco_div_in),
        .band_code    (band_code),
        .pll_loop_en  (pll_loop_en),
        .cal_done     (cal_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int x1_code(input int tgt);
        int c;
        c = tgt - 5;
        if (c < 0)   c = 0;
        if (c > 255) c = 255;
        return c;
    endfunction

    function automatic int dur(input int sel);
        int s;
        s = (sel == 0) ? 0 : (sel == 1) ? 1 : 2;
        return K * (SETTLE + (WIN_BASE >> s) + 1);
    endfunction

    // Pulse start and leave the caller at the negedge after the start edge
    task automatic pulse_start(input int tgt, input int sel);
        @(negedge clk);
        target_count = TGT_W'(tgt);
        rate_sel     = 2'(sel);
        cal_start    = 1'b1;
        @(negedge clk);
        cal_start    = 1'b0;
        check(band_code == K'(MID) && !cal_done && !pll_loop_en, "R2",
              int'(band_code), MID);
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!cal_done && n < 20000) begin
            check(!pll_loop_en, "R5", int'(pll_loop_en), 0);
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(band_code == K'(MID), "R1", int'(band_code), MID);
        check(!cal_done && !pll_loop_en, "R1", int'({cal_done, pll_loop_en}), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_x1(input int tgt, input string tag);
        int n;
        pulse_start(tgt, 0);
        wait_done(n);
        check(n == dur(0), "R6", n, dur(0));
        check(int'(band_code) == x1_code(tgt), tag, int'(band_code), x1_code(tgt));
        check(pll_loop_en && cal_done, "R5", int'({pll_loop_en, cal_done}), 3);
    endtask

    task automatic t_rate(input int sel, input int tgt);
        int n, d, tol;
        pulse_start(tgt, sel);
        wait_done(n);
        check(n == dur(sel), "R6", n, dur(sel));
        d   = int'(band_code) - x1_code(tgt);
        if (d < 0) d = -d;
        tol = 2 << ((sel == 1) ? 1 : 2);
        check(d <= tol, "R7", int'(band_code), x1_code(tgt));
    endtask

    task automatic t_restart;
        int n;
        pulse_start(60, 0);
        repeat (3000) @(negedge clk);
        check(!cal_done && !pll_loop_en, "R8", int'(cal_done), 0);
        pulse_start(150, 0);
        wait_done(n);
        check(n == dur(0), "R8", n, dur(0));
        check(int'(band_code) == x1_code(150), "R8", int'(band_code), x1_code(150));
    endtask

    task automatic t_hold;
        logic [K-1:0] snap;
        snap = band_code;
        target_count = 12'd7;
        rate_sel     = 2'd2;
        repeat (2000) @(negedge clk);
        check(band_code == snap, "R9", int'(band_code), int'(snap));
        check(cal_done && pll_loop_en, "R9", int'({cal_done, pll_loop_en}), 3);
    endtask

    initial begin
        #(4 * 190000);
        check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_x1(100, "R3");     // mid-range code 95
        t_x1(37,  "R3");     // code 32, exercises counter clearing per window
        t_x1(200, "R4");     // code 195
        t_x1(3,   "R4");     // nothing qualifies: all cleared
        t_x1(300, "R4");     // everything qualifies: all kept
        t_x1(9,   "R10");    // low code 4, settling edges must not leak in
        t_rate(1, 100);
        t_rate(2, 100);
        t_rate(3, 180);
        t_restart();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule